// File: doc/BRIEF.md
# Trap Return Unit

This unit carries out the two privileged return operations of a RISC-V style core: the return from a supervisor trap handler and the return from a machine trap handler. A request names which return to perform. It also presents the current privilege, the virtualization flag, a compact status word, the saved supervisor-virtualization bit, the virtual-trap control bit, the two saved exception PCs and a set of feature flags. One cycle later the unit delivers one of two results. A committed return carries the unstacked status word, the new privilege, the new virtualization flag and the return target. An exception carries a cause code and leaves all state untouched.

The surrounding core copies the registered outputs back into its architectural state when `done_o` is high and `exc_o` is low. When `exc_o` is high it takes a trap with `cause_o` instead. When a return moves into a virtualized guest, `swap_o` pulses for that cycle so that the core can exchange its hypervisor register banks.

Privilege encoding: U = 0, S = 1, M = 3. The status word bit layout is: [0] SIE, [1] SPIE, [2] SPP, [3] MIE, [4] MPIE, [6:5] MPP, [7] MPV, [8] MPRV, [9] TSR. Cause codes: misaligned target = 0, instruction access fault = 1, illegal instruction = 2, virtual instruction = 22.

Top module: `trap_ret_unit`

## Requirements
- R1: A supervisor return from U (privilege 0), or a machine return from any privilege other than M (3), raises cause 2. This check wins over every other check.
- R2: When `has_c_i` is 0 and bits [1:0] of the selected return PC are not both zero, the unit raises cause 0. Only R1 takes priority over this check.
- R3: A supervisor return with TSR (bit 9) set from a privilege other than M raises cause 2. Otherwise, when `cur_virt_i` and `vtsr_i` are both 1, it raises cause 22. The TSR check is made first.
- R4: A committed supervisor return sets the new privilege to SPP (0→U, 1→S). It copies SPIE into SIE, sets SPIE to 1 and clears SPP.
- R5: A committed machine return sets the new privilege to MPP and copies MPIE into MIE. It sets MPIE to 1, clears MPV, and writes MPP as U when `has_u_i` is 1 and as M otherwise.
- R6: When `v112_i` is 1, MPRV (bit 8) is cleared on every committed supervisor return, and on a committed machine return whose new privilege is not M. In every other case MPRV is unchanged.
- R7: A committed supervisor return with `has_h_i`=1 and `cur_virt_i`=0 takes the new virtualization flag from `spv_i`, clears `spv_o`, and pulses `swap_o` when `spv_i` was 1. In all other cases the flag and SPV are unchanged.
- R8: A committed machine return with `has_h_i`=1 sets the virtualization flag to MPV AND (new privilege ≠ M), and pulses `swap_o` when that value is 1. With `has_h_i`=0 the flag is unchanged.
- R9: A machine return with `pmp_empty_i`=1 whose MPP is not M raises cause 1. This check comes after R1 and R2.
- R10: Every request produces exactly one `done_o` pulse on the next clock edge. With no request, `done_o` and `swap_o` are 0.
- R11: When an exception is raised, `priv_o`, `virt_o`, `stat_o` and `spv_o` equal the request's inputs and `swap_o` is 0. `ret_pc_o` always carries the selected saved PC.
- R12: After reset, `done_o`=0, `exc_o`=0, `swap_o`=0, `priv_o`=3, `virt_o`=0 and `stat_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Return request this cycle |
| req_mret_i | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv_i | input | 2 | Current privilege |
| cur_virt_i | input | 1 | Current virtualization flag |
| stat_i | input | 10 | Current status word |
| spv_i | input | 1 | Saved supervisor-virtualization bit |
| vtsr_i | input | 1 | Trap supervisor return while virtualized |
| sepc_i | input | XLEN | Supervisor saved PC |
| mepc_i | input | XLEN | Machine saved PC |
| has_c_i | input | 1 | Compressed instructions present |
| has_u_i | input | 1 | User mode present |
| has_h_i | input | 1 | Hypervisor support present |
| pmp_empty_i | input | 1 | PMP implemented with zero rules |
| v112_i | input | 1 | Privileged spec version 1.12 or later |
| done_o | output | 1 | Result valid pulse |
| exc_o | output | 1 | Result is an exception |
| cause_o | output | 5 | Exception cause |
| priv_o | output | 2 | New privilege |
| virt_o | output | 1 | New virtualization flag |
| stat_o | output | 10 | New status word |
| spv_o | output | 1 | New SPV bit |
| ret_pc_o | output | XLEN | Return target |
| swap_o | output | 1 | Register bank swap strobe |

## Verification
Any mistake in the decode or in the stacking shows up on the `done_o` pulse that follows the request, one clock later. A wrong priority order shows up as the wrong `cause_o`. A missed stack step shows up as a wrong SIE/MIE/SPIE/MPIE/MPP bit in `stat_o`. A wrong virtualization rule shows up as a wrong `virt_o` or a missing or extra `swap_o`. A faulty exception path that lets state leak shows up as `stat_o` or `priv_o` differing from the inputs of the request. Because the outputs hold between requests, a corrupted register also stays visible until the next request overwrites it.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;
    localparam int ST_W = 10;

    localparam int ST_SIE  = 0;
    localparam int ST_SPIE = 1;
    localparam int ST_SPP  = 2;
    localparam int ST_MIE  = 3;
    localparam int ST_MPIE = 4;
    localparam int ST_MPPL = 5;
    localparam int ST_MPPH = 6;
    localparam int ST_MPV  = 7;
    localparam int ST_MPRV = 8;
    localparam int ST_TSR  = 9;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [4:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [4:0] CAUSE_ACCESS   = 5'd1;
    localparam logic [4:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [4:0] CAUSE_VIRT     = 5'd22;

    typedef struct packed {
        logic            exc;
        logic [4:0]      cause;
        logic [1:0]      priv;
        logic            virt;
        logic [ST_W-1:0] stat;
        logic            spv;
        logic            swap;
    } ret_res_t;

    typedef struct packed {
        logic     done;
        ret_res_t res;
    } unit_state_t;
endpackage

// File: rtl/tr_sret_calc.sv
module tr_sret_calc
    import trap_ret_pkg::*;
(
    input  logic [1:0]      cur_priv_i,
    input  logic            cur_virt_i,
    input  logic [ST_W-1:0] stat_i,
    input  logic            spv_i,
    input  logic            vtsr_i,
    input  logic [1:0]      pc_low_i,
    input  logic            has_c_i,
    input  logic            has_h_i,
    input  logic            v112_i,
    output ret_res_t        res_o
);
    always_comb begin
        res_o       = '0;
        res_o.priv  = cur_priv_i;
        res_o.virt  = cur_virt_i;
        res_o.stat  = stat_i;
        res_o.spv   = spv_i;
        if (cur_priv_i < PRIV_S) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_ILLEGAL;
        end else if (!has_c_i && (pc_low_i != 2'b00)) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_MISALIGN;
        end else if (stat_i[ST_TSR] && (cur_priv_i != PRIV_M)) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_ILLEGAL;
        end else if (cur_virt_i && vtsr_i) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_VIRT;
        end else begin
            res_o.priv           = stat_i[ST_SPP] ? PRIV_S : PRIV_U;
            res_o.stat[ST_SIE]   = stat_i[ST_SPIE];
            res_o.stat[ST_SPIE]  = 1'b1;
            res_o.stat[ST_SPP]   = 1'b0;
            if (v112_i) begin
                res_o.stat[ST_MPRV] = 1'b0;
            end
            if (has_h_i && !cur_virt_i) begin
                res_o.virt = spv_i;
                res_o.spv  = 1'b0;
                res_o.swap = spv_i;
            end
        end
    end
endmodule

// File: rtl/tr_mret_calc.sv
module tr_mret_calc
    import trap_ret_pkg::*;
(
    input  logic [1:0]      cur_priv_i,
    input  logic            cur_virt_i,
    input  logic [ST_W-1:0] stat_i,
    input  logic            spv_i,
    input  logic [1:0]      pc_low_i,
    input  logic            has_c_i,
    input  logic            has_u_i,
    input  logic            has_h_i,
    input  logic            pmp_empty_i,
    input  logic            v112_i,
    output ret_res_t        res_o
);
    logic [1:0] tgt_priv;
    logic       tgt_virt;

    assign tgt_priv = stat_i[ST_MPPH:ST_MPPL];
    assign tgt_virt = stat_i[ST_MPV] && (tgt_priv != PRIV_M);

    always_comb begin
        res_o       = '0;
        res_o.priv  = cur_priv_i;
        res_o.virt  = cur_virt_i;
        res_o.stat  = stat_i;
        res_o.spv   = spv_i;
        if (cur_priv_i != PRIV_M) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_ILLEGAL;
        end else if (!has_c_i && (pc_low_i != 2'b00)) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_MISALIGN;
        end else if (pmp_empty_i && (tgt_priv != PRIV_M)) begin
            res_o.exc   = 1'b1;
            res_o.cause = CAUSE_ACCESS;
        end else begin
            res_o.priv                 = tgt_priv;
            res_o.stat[ST_MIE]         = stat_i[ST_MPIE];
            res_o.stat[ST_MPIE]        = 1'b1;
            res_o.stat[ST_MPPH:ST_MPPL] = has_u_i ? PRIV_U : PRIV_M;
            res_o.stat[ST_MPV]         = 1'b0;
            if (v112_i && (tgt_priv != PRIV_M)) begin
                res_o.stat[ST_MPRV] = 1'b0;
            end
            if (has_h_i) begin
                res_o.virt = tgt_virt;
                res_o.swap = tgt_virt;
            end
        end
    end
endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
    import trap_ret_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic            req_mret_i,
    input  logic [1:0]      cur_priv_i,
    input  logic            cur_virt_i,
    input  logic [ST_W-1:0] stat_i,
    input  logic            spv_i,
    input  logic            vtsr_i,
    input  logic [XLEN-1:0] sepc_i,
    input  logic [XLEN-1:0] mepc_i,
    input  logic            has_c_i,
    input  logic            has_u_i,
    input  logic            has_h_i,
    input  logic            pmp_empty_i,
    input  logic            v112_i,
    output logic            done_o,
    output logic            exc_o,
    output logic [4:0]      cause_o,
    output logic [1:0]      priv_o,
    output logic            virt_o,
    output logic [ST_W-1:0] stat_o,
    output logic            spv_o,
    output logic [XLEN-1:0] ret_pc_o,
    output logic            swap_o
);
    localparam int ALIGN_W = 2;

    ret_res_t          s_res;
    ret_res_t          m_res;
    unit_state_t       st_d, st_q;
    logic [XLEN-1:0]   pc_d, pc_q;

    tr_sret_calc u_sret (
        .cur_priv_i (cur_priv_i),
        .cur_virt_i (cur_virt_i),
        .stat_i     (stat_i),
        .spv_i      (spv_i),
        .vtsr_i     (vtsr_i),
        .pc_low_i   (sepc_i[ALIGN_W-1:0]),
        .has_c_i    (has_c_i),
        .has_h_i    (has_h_i),
        .v112_i     (v112_i),
        .res_o      (s_res)
    );

    tr_mret_calc u_mret (
        .cur_priv_i  (cur_priv_i),
        .cur_virt_i  (cur_virt_i),
        .stat_i      (stat_i),
        .spv_i       (spv_i),
        .pc_low_i    (mepc_i[ALIGN_W-1:0]),
        .has_c_i     (has_c_i),
        .has_u_i     (has_u_i),
        .has_h_i     (has_h_i),
        .pmp_empty_i (pmp_empty_i),
        .v112_i      (v112_i),
        .res_o       (m_res)
    );

    always_comb begin
        st_d          = st_q;
        st_d.done     = 1'b0;
        st_d.res.exc  = 1'b0;
        st_d.res.swap = 1'b0;
        pc_d          = pc_q;
        if (req_valid_i) begin
            st_d.done = 1'b1;
            st_d.res  = req_mret_i ? m_res : s_res;
            pc_d      = req_mret_i ? mepc_i : sepc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.res.priv <= PRIV_M;
            pc_q          <= '0;
        end else begin
            st_q <= st_d;
            pc_q <= pc_d;
        end
    end

    assign done_o   = st_q.done;
    assign exc_o    = st_q.res.exc;
    assign cause_o  = st_q.res.cause;
    assign priv_o   = st_q.res.priv;
    assign virt_o   = st_q.res.virt;
    assign stat_o   = st_q.res.stat;
    assign spv_o    = st_q.res.spv;
    assign swap_o   = st_q.res.swap;
    assign ret_pc_o = pc_q;
endmodule

// File: rtl/trap_ret_chk.sv
module trap_ret_chk
    import trap_ret_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid_i,
    input logic            req_mret_i,
    input logic [1:0]      cur_priv_i,
    input logic            cur_virt_i,
    input logic [ST_W-1:0] stat_i,
    input logic            spv_i,
    input logic            has_c_i,
    input logic [1:0]      sepc_low,
    input logic [1:0]      mepc_low,
    input logic            done_o,
    input logic            exc_o,
    input logic [4:0]      cause_o,
    input logic [1:0]      priv_o,
    input logic            virt_o,
    input logic [ST_W-1:0] stat_o,
    input logic            spv_o,
    input logic            swap_o
);
    // R10
    done_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> done_o);

    // R10
    no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!done_o && !swap_o));

    // R11
    exc_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (!exc_o || (stat_o == $past(stat_i) && priv_o == $past(cur_priv_i)
                         && virt_o == $past(cur_virt_i) && spv_o == $past(spv_i) && !swap_o)));

    // R1
    sret_low_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_mret_i && cur_priv_i == PRIV_U) |=> (exc_o && cause_o == CAUSE_ILLEGAL));

    // R2
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && cur_priv_i == PRIV_M && !has_c_i
         && ((req_mret_i ? mepc_low : sepc_low) != 2'b00)) |=> (exc_o && cause_o == CAUSE_MISALIGN));

    // R5
    mret_unstack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_mret_i) |=> (exc_o || (!stat_o[ST_MPV] && stat_o[ST_MPIE])));

    // R7
    swap_only_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swap_o |-> (done_o && !exc_o && virt_o));
endmodule

bind trap_ret_unit trap_ret_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_mret_i  (req_mret_i),
    .cur_priv_i  (cur_priv_i),
    .cur_virt_i  (cur_virt_i),
    .stat_i      (stat_i),
    .spv_i       (spv_i),
    .has_c_i     (has_c_i),
    .sepc_low    (sepc_i[1:0]),
    .mepc_low    (mepc_i[1:0]),
    .done_o      (done_o),
    .exc_o       (exc_o),
    .cause_o     (cause_o),
    .priv_o      (priv_o),
    .virt_o      (virt_o),
    .stat_o      (stat_o),
    .spv_o       (spv_o),
    .swap_o      (swap_o)
);

// File: tb/trap_ret_unit_tb_top.sv
module trap_ret_unit_tb_top;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid_i = 1'b0;
    logic            req_mret_i = 1'b0;
    logic [1:0]      cur_priv_i = 2'd3;
    logic            cur_virt_i = 1'b0;
    logic [9:0]      stat_i = '0;
    logic            spv_i = 1'b0;
    logic            vtsr_i = 1'b0;
    logic [XLEN-1:0] sepc_i = '0;
    logic [XLEN-1:0] mepc_i = '0;
    logic            has_c_i = 1'b1;
    logic            has_u_i = 1'b1;
    logic            has_h_i = 1'b1;
    logic            pmp_empty_i = 1'b0;
    logic            v112_i = 1'b1;
    logic            done_o, exc_o, virt_o, spv_o, swap_o;
    logic [4:0]      cause_o;
    logic [1:0]      priv_o;
    logic [9:0]      stat_o;
    logic [XLEN-1:0] ret_pc_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trap_ret_unit #(.XLEN(XLEN)) dut_i (.*);

    typedef struct {
        logic            mret;
        logic [1:0]      priv;
        logic            virt;
        logic [9:0]      stat;
        logic            spv;
        logic            vtsr;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] mepc;
        logic            fc, fu, fh, fpmp, f112;
    } stim_t;

    typedef struct {
        string           tag;
        logic            exc;
        logic [4:0]      cause;
        logic [1:0]      priv;
        logic            virt;
        logic [9:0]      stat;
        logic            spv;
        logic            swap;
        logic [XLEN-1:0] pc;
    } exp_t;

    exp_t sb_q[$];

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic stim_t base();
        stim_t s;
        s.mret = 1'b0; s.priv = 2'd3; s.virt = 1'b0; s.stat = '0; s.spv = 1'b0;
        s.vtsr = 1'b0; s.sepc = 32'h100; s.mepc = 32'h200;
        s.fc = 1'b1; s.fu = 1'b1; s.fh = 1'b1; s.fpmp = 1'b0; s.f112 = 1'b1;
        return s;
    endfunction

    function automatic exp_t model(stim_t s, string tag);
        exp_t e;
        logic [1:0] np;
        logic       pv;
        e.tag = tag; e.exc = 1'b0; e.cause = '0; e.swap = 1'b0;
        e.priv = s.priv; e.virt = s.virt; e.stat = s.stat; e.spv = s.spv;
        e.pc = s.mret ? s.mepc : s.sepc;
        if (!s.mret) begin
            if (s.priv == 2'd0) begin e.exc = 1'b1; e.cause = 5'd2; end
            else if (!s.fc && e.pc[1:0] != 2'b00) begin e.exc = 1'b1; e.cause = 5'd0; end
            else if (s.stat[9] && s.priv != 2'd3) begin e.exc = 1'b1; e.cause = 5'd2; end
            else if (s.virt && s.vtsr) begin e.exc = 1'b1; e.cause = 5'd22; end
            else begin
                e.priv = s.stat[2] ? 2'd1 : 2'd0;
                e.stat[0] = s.stat[1];
                e.stat[1] = 1'b1;
                e.stat[2] = 1'b0;
                if (s.f112) e.stat[8] = 1'b0;
                if (s.fh && !s.virt) begin
                    e.virt = s.spv; e.swap = s.spv; e.spv = 1'b0;
                end
            end
        end else begin
            np = s.stat[6:5];
            pv = s.stat[7] && (np != 2'd3);
            if (s.priv != 2'd3) begin e.exc = 1'b1; e.cause = 5'd2; end
            else if (!s.fc && e.pc[1:0] != 2'b00) begin e.exc = 1'b1; e.cause = 5'd0; end
            else if (s.fpmp && np != 2'd3) begin e.exc = 1'b1; e.cause = 5'd1; end
            else begin
                e.priv = np;
                e.stat[3] = s.stat[4];
                e.stat[4] = 1'b1;
                e.stat[6:5] = s.fu ? 2'd0 : 2'd3;
                e.stat[7] = 1'b0;
                if (s.f112 && np != 2'd3) e.stat[8] = 1'b0;
                if (s.fh) begin e.virt = pv; e.swap = pv; end
            end
        end
        return e;
    endfunction

    task automatic send(stim_t s, string tag);
        @(negedge clk);
        req_valid_i = 1'b1; req_mret_i = s.mret; cur_priv_i = s.priv; cur_virt_i = s.virt;
        stat_i = s.stat; spv_i = s.spv; vtsr_i = s.vtsr; sepc_i = s.sepc; mepc_i = s.mepc;
        has_c_i = s.fc; has_u_i = s.fu; has_h_i = s.fh; pmp_empty_i = s.fpmp; v112_i = s.f112;
        sb_q.push_back(model(s, tag));
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Monitor: compares each result pulse against the oldest expected item
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb_q.size() == 0) begin
                check("R10 unexpected done", 64'(done_o), 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.tag, " exc"},   64'(exc_o),    64'(e.exc));
                check({e.tag, " cause"}, 64'(cause_o),  64'(e.cause));
                check({e.tag, " priv"},  64'(priv_o),   64'(e.priv));
                check({e.tag, " virt"},  64'(virt_o),   64'(e.virt));
                check({e.tag, " stat"},  64'(stat_o),   64'(e.stat));
                check({e.tag, " spv"},   64'(spv_o),    64'(e.spv));
                check({e.tag, " swap"},  64'(swap_o),   64'(e.swap));
                check({e.tag, " pc"},    64'(ret_pc_o), 64'(e.pc));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 done", 64'(done_o), 64'd0);
        check("R12 exc", 64'(exc_o), 64'd0);
        check("R12 swap", 64'(swap_o), 64'd0);
        check("R12 priv", 64'(priv_o), 64'd3);
        check("R12 virt", 64'(virt_o), 64'd0);
        check("R12 stat", 64'(stat_o), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 idle done", 64'(done_o), 64'd0);

        // R4 supervisor return to U, R6 MPRV cleared
        s = base(); s.priv = 2'd1; s.stat = 10'b01_0000_0010; send(s, "R4 sret to U");
        s = base(); s.priv = 2'd3; s.stat = 10'b00_0000_0100; s.f112 = 1'b0; s.stat[8] = 1'b1;
        send(s, "R6 sret old spec keeps MPRV");
        // R1 privilege checks and priority over misalignment
        s = base(); s.priv = 2'd0; s.fc = 1'b0; s.sepc = 32'h102; send(s, "R1 sret from U");
        s = base(); s.mret = 1'b1; s.priv = 2'd1; send(s, "R1 mret from S");
        // R2 misaligned target
        s = base(); s.fc = 1'b0; s.sepc = 32'h102; send(s, "R2 sret misaligned");
        s = base(); s.mret = 1'b1; s.fc = 1'b0; s.mepc = 32'h201; send(s, "R2 mret misaligned");
        s = base(); s.mret = 1'b1; s.fc = 1'b1; s.mepc = 32'h202; send(s, "R2 compressed allows half");
        // R3 TSR and VTSR
        s = base(); s.priv = 2'd1; s.stat[9] = 1'b1; s.virt = 1'b1; s.vtsr = 1'b1; send(s, "R3 TSR first");
        s = base(); s.priv = 2'd3; s.stat[9] = 1'b1; send(s, "R3 TSR ignored at M");
        s = base(); s.priv = 2'd1; s.virt = 1'b1; s.vtsr = 1'b1; send(s, "R3 VTSR virtual fault");
        // R7 hypervisor supervisor return
        s = base(); s.priv = 2'd1; s.spv = 1'b1; s.stat[2] = 1'b1; send(s, "R7 sret into guest");
        s = base(); s.priv = 2'd1; s.virt = 1'b1; s.spv = 1'b1; send(s, "R7 sret virtualized keeps SPV");
        // R5 machine return stacking
        s = base(); s.mret = 1'b1; s.stat = 10'b00_0111_0000; s.fu = 1'b0; send(s, "R5 mret no user mode");
        s = base(); s.mret = 1'b1; s.stat = 10'b01_0011_0000; send(s, "R5 mret to S");
        // R6 MPRV on machine return
        s = base(); s.mret = 1'b1; s.stat = 10'b01_0110_0000; send(s, "R6 mret to M keeps MPRV");
        // R8 machine return virtualization
        s = base(); s.mret = 1'b1; s.stat = 10'b00_1010_0000; send(s, "R8 mret into guest");
        s = base(); s.mret = 1'b1; s.stat = 10'b00_1110_0000; send(s, "R8 mret to M no virt");
        s = base(); s.mret = 1'b1; s.fh = 1'b0; s.virt = 1'b1; s.stat = 10'b00_1010_0000;
        send(s, "R8 mret without hypervisor");
        // R9 PMP with no rules
        s = base(); s.mret = 1'b1; s.fpmp = 1'b1; s.stat = 10'b00_0010_0000; send(s, "R9 pmp empty to S");
        s = base(); s.mret = 1'b1; s.fpmp = 1'b1; s.stat = 10'b00_0110_0000; send(s, "R9 pmp empty to M");
        // R11 mixed random traffic, exception paths included
        for (int i = 0; i < 300; i++) begin
            s.mret = 1'($urandom); s.priv = 2'($urandom); s.virt = 1'($urandom);
            s.stat = 10'($urandom); s.spv = 1'($urandom); s.vtsr = 1'($urandom);
            s.sepc = $urandom; s.mepc = $urandom;
            s.fc = 1'($urandom); s.fu = 1'($urandom); s.fh = 1'($urandom);
            s.fpmp = 1'($urandom); s.f112 = 1'($urandom);
            send(s, "R11 random mix");
        end
        repeat (3) @(negedge clk);
        check("R10 queue drained", 64'(sb_q.size()), 64'd0);
        check("R10 done idle", 64'(done_o), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule